// File: doc/BRIEF.md
# Address-Polling Bus Arbiter

This block hands a shared bus to one of several masters by calling them in turn. Every master raises its own request. The OR of all requests acts as the shared "someone wants the bus" line. While that line is high and nobody holds the bus, the arbiter drives a master number onto an encoded poll bus. The number moves to the next value on every clock and goes back to zero after the last master.

Each master has a small comparator beside it that checks the poll bus against its fixed number. If that master is requesting when its number appears, it wins. The busy flag rises and its ownership bit is set. The poll bus then freezes until the owner pulses its release line. After the release, polling carries on from the number after the one that just owned the bus. That gives every master a turn.

The poll bus is ceil(log2 N) bits wide, so eight masters use three lines. All pins are plain control levels. No data moves through the block, so it has no valid/ready stream and no back-pressure rules.

Top module: `poll_arbiter`

## Requirements
- R1: While reset is asserted (`rst_ni` low, asynchronous), `poll_addr_o` is 0, `busy_o` is 0 and `own_o` is all zeros.
- R2: With the bus free and no request bit set, `poll_addr_o` keeps its value and `busy_o` stays 0.
- R3: With the bus free, at least one request set, and the polled master not requesting, `poll_addr_o` goes up by one on the next clock, and goes from N-1 back to 0. A master that is not requesting is skipped when its number is polled.
- R4: With the bus free, if `req_i[k]` is set while `poll_addr_o` equals k, then on the next clock `busy_o` is 1, `own_o` has only bit k set, and `poll_addr_o` still equals k.
- R5: While `busy_o` is 1 and the owner does not release, `poll_addr_o`, `busy_o` and `own_o` all keep their values, whatever the other masters request.
- R6: While `busy_o` is 1, a pulse on `rel_i[k]` from the owner k clears `busy_o` and `own_o` on the next clock. In that same clock, `poll_addr_o` moves to the number after k, with wrap. The bus cannot be granted again in the clock that releases it.
- R7: A `rel_i` bit from a master that does not own the bus has no effect, and neither does any `rel_i` bit while the bus is free.
- R8: `own_o` has at most one bit set, and `busy_o` is 1 exactly when some bit of `own_o` is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | N_MASTERS | Per-master bus request, level |
| rel_i | input | N_MASTERS | Per-master release, only the owner's bit counts |
| poll_addr_o | output | ADDR_W | Number of the master being polled |
| busy_o | output | 1 | Bus is held by a master |
| own_o | output | N_MASTERS | One-hot ownership, bit k means master k holds the bus |

## Verification
Two events can fall in the same clock: the owner releasing the bus, and a waiting master whose number is the next one to be polled. The bench sets up the case where master 5 owns the bus and master 6 is requesting, then releases master 5. It expects one clock with the bus free and the poll number at 6, and master 6 to own the bus one clock after that. A second case is the owner releasing while its own request is still high. There the bench expects the poll number to move past it, not to hand the bus straight back. A behavioural model runs beside the design and is compared with it on every clock. A randomized phase piles releases, foreign releases and requests into the same clocks.

// File: rtl/poll_arb_pkg.sv
package poll_arb_pkg;

  // Next poll number with wrap after the last master.
  function automatic int unsigned wrap_next(input int unsigned cur, input int unsigned count);
    return (cur + 1 >= count) ? 0 : cur + 1;
  endfunction

endpackage

// File: rtl/poll_addr_gen.sv
module poll_addr_gen #(
  parameter int N_MASTERS = 8,
  parameter int ADDR_W    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              step_i,
  output logic [ADDR_W-1:0] addr_o
);
  import poll_arb_pkg::*;

  logic [ADDR_W-1:0] addr_q;
  logic [ADDR_W-1:0] addr_next;

  always_comb begin
    addr_next = ADDR_W'(wrap_next(int'(addr_q), N_MASTERS));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      addr_q <= '0;
    end else if (step_i) begin
      addr_q <= addr_next;
    end
  end

  assign addr_o = addr_q;

  // The counter never leaves the master range.
  p_addr_in_range_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(addr_q) < N_MASTERS);

endmodule

// File: rtl/poll_match.sv
module poll_match #(
  parameter int ADDR_W = 3,
  parameter int MY_ID  = 0
) (
  input  logic              req_i,
  input  logic              free_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic              hit_o
);
  logic addr_eq;

  always_comb begin
    addr_eq = (addr_i == ADDR_W'(MY_ID));
    hit_o   = free_i & req_i & addr_eq;
  end

endmodule

// File: rtl/grant_keeper.sv
module grant_keeper #(
  parameter int N_MASTERS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] hit_i,
  input  logic [N_MASTERS-1:0] rel_i,
  output logic                 busy_o,
  output logic [N_MASTERS-1:0] own_o,
  output logic                 drop_o
);
  logic                 busy_q;
  logic [N_MASTERS-1:0] own_q;
  logic                 claim;

  always_comb begin
    drop_o = busy_q & (|(rel_i & own_q));
    claim  = ~busy_q & (|hit_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      own_q  <= '0;
    end else if (drop_o) begin
      busy_q <= 1'b0;
      own_q  <= '0;
    end else if (claim) begin
      busy_q <= 1'b1;
      own_q  <= hit_i;
    end
  end

  assign busy_o = busy_q;
  assign own_o  = own_q;

  // Only one local comparator can match a given poll number.
  p_single_hit_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(hit_i));

  p_owner_onehot_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(own_q));

  p_busy_owner_agree_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q == (own_q != '0));

endmodule

// File: rtl/poll_arbiter.sv
module poll_arbiter #(
  parameter int N_MASTERS = 8,
  parameter int ADDR_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic [N_MASTERS-1:0] req_i,
  input  logic [N_MASTERS-1:0] rel_i,
  output logic [ADDR_W-1:0]    poll_addr_o,
  output logic                 busy_o,
  output logic [N_MASTERS-1:0] own_o
);
  logic                 any_req;
  logic                 free;
  logic                 drop;
  logic                 step;
  logic [N_MASTERS-1:0] hit;

  assign any_req = |req_i;
  assign free    = ~busy_o & any_req;

  // Step while polling without a match, or once on release.
  assign step = (free & ~(|hit)) | drop;

  poll_addr_gen #(
    .N_MASTERS (N_MASTERS),
    .ADDR_W    (ADDR_W)
  ) u_addr (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .step_i (step),
    .addr_o (poll_addr_o)
  );

  for (genvar g = 0; g < N_MASTERS; g++) begin : g_match
    poll_match #(
      .ADDR_W (ADDR_W),
      .MY_ID  (g)
    ) u_match (
      .req_i  (req_i[g]),
      .free_i (free),
      .addr_i (poll_addr_o),
      .hit_o  (hit[g])
    );
  end

  grant_keeper #(
    .N_MASTERS (N_MASTERS)
  ) u_grant (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .hit_i  (hit),
    .rel_i  (rel_i),
    .busy_o (busy_o),
    .own_o  (own_o),
    .drop_o (drop)
  );

  p_idle_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i == '0) |=> ($stable(poll_addr_o) && !busy_o));

  p_skip_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i != '0 && ((req_i >> poll_addr_o) & 1) == 0)
      |=> (poll_addr_o == (($past(poll_addr_o) == ADDR_W'(N_MASTERS-1)) ?
                           '0 : $past(poll_addr_o) + 1'b1)));

  p_claim_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && ((req_i >> poll_addr_o) & 1) == 1)
      |=> (busy_o && own_o == (N_MASTERS'(1) << $past(poll_addr_o)) && $stable(poll_addr_o)));

  p_hold_busy_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (rel_i & own_o) == '0) |=> ($stable(poll_addr_o) && $stable(own_o) && busy_o));

  p_release_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && (rel_i & own_o) != '0) |=> (!busy_o && own_o == '0));

  p_free_rel_ignored_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_o && req_i == '0 && rel_i != '0) |=> (own_o == '0));

endmodule

// File: tb/poll_arbiter_bench.sv
module poll_arbiter_bench;
  localparam int N  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  req = '0;
  logic [N-1:0]  rel = '0;
  logic [AW-1:0] poll_addr;
  logic          busy;
  logic [N-1:0]  own;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  // Behavioural reference state
  int    m_addr  = 0;
  int    m_busy  = 0;
  int    m_owner = -1;
  string m_tag   = "R1";

  always #10 clk = ~clk;

  poll_arbiter #(.N_MASTERS(N)) u_poll_arbiter (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .req_i       (req),
    .rel_i       (rel),
    .poll_addr_o (poll_addr),
    .busy_o      (busy),
    .own_o       (own)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (!rst_n) begin
      m_addr <= 0; m_busy <= 0; m_owner <= -1; m_tag <= "R1";
    end else if (m_busy != 0) begin
      if (rel[m_owner]) begin
        m_busy <= 0; m_owner <= -1; m_addr <= (m_addr + 1) % N; m_tag <= "R6";
      end else begin
        m_tag <= (rel != 0) ? "R7" : "R5";
      end
    end else if (req == 0) begin
      m_tag <= (rel != 0) ? "R7" : "R2";
    end else if (req[m_addr]) begin
      m_busy <= 1; m_owner <= m_addr; m_tag <= "R4";
    end else begin
      m_addr <= (m_addr + 1) % N; m_tag <= "R3";
    end
  end

  task automatic check(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    int exp_own;
    exp_own = (m_owner >= 0) ? (1 << m_owner) : 0;
    check(m_tag, int'(poll_addr), m_addr, "poll_addr");
    check(m_tag, int'(busy), m_busy, "busy");
    check(m_tag, int'(own), exp_own, "own");
    check("R8", int'(busy), (own != 0) ? 1 : 0, "busy vs own");
  endtask

  task automatic tick(input logic [N-1:0] r, input logic [N-1:0] l);
    @(negedge clk);
    compare_all();
    req = r;
    rel = l;
  endtask

  initial begin
    // R1: reset state
    #5;
    check("R1", int'(poll_addr), 0, "poll_addr in reset");
    check("R1", int'(busy), 0, "busy in reset");
    check("R1", int'(own), 0, "own in reset");
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    // R2 idle, R7 release while free
    repeat (3) tick('0, '0);
    tick('0, 8'h10);
    tick('0, '0);
    // R3 skip, R4 claim master 5
    tick(8'h20, '0);
    repeat (8) tick(8'h20, '0);
    // R5 others request during hold, R7 foreign release
    repeat (3) tick(8'hE4, '0);
    tick(8'hE4, 8'h04);
    tick(8'h60, '0);
    // R6 release with master 6 waiting: next number is 6
    tick(8'h60, 8'h20);
    tick(8'h60, '0);
    repeat (2) tick(8'h60, '0);
    // release 6 while its request stays high: must move past it
    tick(8'h41, 8'h40);
    // R3 wrap to master 0
    repeat (4) tick(8'h41, '0);
    tick(8'h40, 8'h01);
    repeat (12) tick(8'h00, '0);
    // Random phase
    for (int i = 0; i < 400; i++) begin
      logic [N-1:0] r;
      logic [N-1:0] l;
      r = N'($urandom);
      if ($urandom_range(0, 3) == 0) r = '0;
      l = ($urandom_range(0, 4) == 0) ? N'($urandom) : '0;
      if (m_owner >= 0 && $urandom_range(0, 3) == 0) l[m_owner] = 1'b1;
      tick(r, l);
    end
    tick('0, '0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    wait (cycles > 5000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual %0d expected below %0d cycles", cycles, 5000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule